// File: doc/BRIEF.md
# I/O MMU Translation-Context Register Bank

This block holds the per-context configuration and fault state of an I/O memory management unit that serves up to eight translation contexts. Software reaches it through a plain 32-bit register port: a write strobe with address and data, and a read-data output that always reflects the register selected by the current address. Each context owns a 64-byte window. The window holds a control word, table-base and table-control words, bus and cache-address words, two memory-attribute words, a status word and a read-only fault address. The whole bank is decoded a second time at a fixed alias offset.

A translation engine reports faults through a one-cycle capture pulse. The pulse carries the context number, the fault flags, an error code, a fault level and a 40-bit faulting address. The first fault in a context is latched. Any later fault in that context is dropped until software clears the status by writing zero to it. Setting the flush bit in the control word starts a TLB invalidation, which is modelled as a busy period of fixed length. The flush bit reads back as busy and drops by itself when the period ends. A single interrupt line is the OR of all contexts whose interrupt enable is set and whose status holds a fault flag.

Top module: `iomcx_regbank`

## Requirements
- R1: Address bits [8:6] select the context and bits [5:2] select the word within the 64-byte window. An address whose context is NUM_CTX or above, or whose bits [10:9] are not both zero, reads as zero, and a write to it changes nothing. A fault pulse naming such a context is ignored.
- R2: Address bit 11 is not decoded, so offset 0x800 plus any address reaches the same register as the address itself, for both reads and writes.
- R3: In the control word (offset 0x00), bits 0, 2, 3, 5:4, 16 and 17 read back as last written. Bit 2 is the interrupt enable. All other bits except bit 1 read as zero.
- R4: Writing the control word with bit 1 set makes bit 1 read 1 from the next cycle for exactly FLUSH_LAT cycles, after which it reads 0. A further write with bit 1 set restarts the full count. A write with bit 1 clear does not end a running count.
- R5: Words at offsets 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18, 0x1C, 0x28 and 0x2C store all 32 written bits. Offsets with no register read zero.
- R6: A fault pulse with a nonzero flag field, into a context with no flag pending, loads the status word at offset 0x20. The flags go to bit 0 (translation fault), bit 1 (page fault), bit 2 (walk abort) and bit 4 (multiple hit), taken from flag inputs 0 to 3. The code goes to bits 10:8 and the level to bits 13:12. The address low 32 bits read at 0x30, and the high 8 bits read at 0x34[7:0].
- R7: While any status flag of a context is set, a fault pulse into that context leaves its status and fault address unchanged. A pulse with an all-zero flag field is ignored.
- R8: Writing zero to the status word clears all of its fields. A nonzero write to it has no effect, and the fault address words cannot be written. When a clearing write and a fault pulse reach the same context in one cycle, the fault is captured.
- R9: The interrupt output is high exactly when some context has its interrupt enable set and at least one status flag set. It follows the registers in the same cycle.
- R10: After reset every register reads zero, no flush is busy and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| flt_valid | input | 1 | Fault capture pulse |
| flt_ctx | input | 3 | Context that faulted |
| flt_flags | input | 4 | Multi-hit, abort, page fault, translation fault (bits 3..0) |
| flt_code | input | 3 | Error code |
| flt_level | input | 2 | Table level of the fault |
| flt_addr | input | 40 | Faulting address |
| irq | output | 1 | Combined interrupt request |

## Verification
Two situations are hard to reach from the ports. The first is a clearing write to a status word that meets a fault pulse for the same context in the same cycle. The stimulus first latches a fault in the context and then drives the next fault pulse on the exact cycle of the zero write, so the capture only succeeds if the clear is seen first. The second is a flush restart. A second flush is issued one cycle into a running count, and a non-flush control write is issued mid-count. Both are checked cycle by cycle against the busy length a reference model predicts.

// File: rtl/iomcx_pkg.sv
package iomcx_pkg;

   localparam int unsigned WORD_W   = 32;
   localparam int unsigned FADDR_W  = 40;
   localparam int unsigned FAHI_W   = FADDR_W - WORD_W;
   localparam int unsigned CTX_MAX  = 8;
   localparam int unsigned CTX_W    = $clog2(CTX_MAX);
   localparam int unsigned IDX_W    = 4;
   localparam int unsigned N_WORDS  = 1 << IDX_W;

   // word index inside one context window
   localparam logic [IDX_W-1:0] IDX_CTRL = 4'h0;
   localparam logic [IDX_W-1:0] IDX_STAT = 4'h8;
   localparam logic [IDX_W-1:0] IDX_FALO = 4'hC;
   localparam logic [IDX_W-1:0] IDX_FAHI = 4'hD;

   // words that are plain storage: 1..7, 10, 11
   localparam logic [N_WORDS-1:0] PLAIN_MASK = 16'b0000_1100_1111_1110;

   // writable control bits, flush bit excluded
   localparam logic [WORD_W-1:0] CTRL_MASK = 32'h0003_003D;
   localparam int unsigned CTRL_FLUSH_BIT = 1;
   localparam int unsigned CTRL_IEN_BIT   = 2;

   typedef struct packed {
      logic [1:0]         level;
      logic [2:0]         code;
      logic [3:0]         flags;
      logic [FADDR_W-1:0] addr;
   } fault_t;

   function automatic logic [WORD_W-1:0] stat_word(input logic [3:0] flags,
                                                   input logic [2:0] code,
                                                   input logic [1:0] level);
      return {18'd0, level, 1'b0, code, 3'd0, flags[3], 1'b0, flags[2:0]};
   endfunction

endpackage

// File: rtl/iomcx_addr_dec.sv
module iomcx_addr_dec
   import iomcx_pkg::*;
#(
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned NUM_CTX = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [CTX_W-1:0]  ctx,
   output logic [IDX_W-1:0]  idx,
   output logic              hit
);
   localparam logic [CTX_W:0] CTX_LIMIT = (CTX_W+1)'(NUM_CTX);

   logic upper_zero;
   logic unused_dec;

   generate
      if (ADDR_W > 12) begin : g_wide
         assign upper_zero = (addr[ADDR_W-1:12] == '0);
      end else begin : g_narrow
         assign upper_zero = 1'b1;
      end
   endgenerate

   assign ctx = addr[8:6];
   assign idx = addr[5:2];
   assign hit = upper_zero && (addr[10:9] == 2'b00) && ({1'b0, ctx} < CTX_LIMIT);

   // bit 11 selects the alias window and is folded away; byte lanes unused
   assign unused_dec = ^{addr[11], addr[1:0]};

endmodule

// File: rtl/iomcx_flush_timer.sv
module iomcx_flush_timer #(
   parameter int unsigned LAT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int unsigned CNT_W = $clog2(LAT + 1);

   generate
      if (LAT < 1) begin : g_bad_lat
         $error("iomcx_flush_timer: LAT must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (start)          cnt_q <= CNT_W'(LAT);
      else if (cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
   end

   assign busy = (cnt_q != '0);

endmodule

// File: rtl/iomcx_ctx.sv
module iomcx_ctx
   import iomcx_pkg::*;
#(
   parameter int unsigned FLUSH_LAT = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  idx,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] rdata,
   input  logic              flt_en,
   input  fault_t            flt,
   output logic              irq,
   output logic              busy,
   output logic              pend
);
   logic [WORD_W-1:0]              ctrl_q;
   logic [3:0]                     flags_q;
   logic [2:0]                     code_q;
   logic [1:0]                     level_q;
   logic [FADDR_W-1:0]             fa_q;
   logic [N_WORDS-1:0][WORD_W-1:0] plain_w;

   logic wr_ctrl, flush_req, stat_clr, pend_eff, take;

   assign wr_ctrl   = wr_en && (idx == IDX_CTRL);
   assign flush_req = wr_ctrl && wdata[CTRL_FLUSH_BIT];
   assign stat_clr  = wr_en && (idx == IDX_STAT) && (wdata == '0);
   assign pend_eff  = stat_clr ? 1'b0 : (flags_q != 4'd0);
   assign take      = flt_en && (flt.flags != 4'd0) && !pend_eff;

   iomcx_flush_timer #(.LAT(FLUSH_LAT)) u_flush (
      .clk   (clk),
      .rst_n (rst_n),
      .start (flush_req),
      .busy  (busy)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= wdata & CTRL_MASK;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags_q <= '0;
         code_q  <= '0;
         level_q <= '0;
         fa_q    <= '0;
      end else if (take) begin
         flags_q <= flt.flags;
         code_q  <= flt.code;
         level_q <= flt.level;
         fa_q    <= flt.addr;
      end else if (stat_clr) begin
         flags_q <= '0;
         code_q  <= '0;
         level_q <= '0;
      end
   end

   generate
      for (genvar w = 0; w < N_WORDS; w++) begin : g_word
         if (PLAIN_MASK[w]) begin : g_store
            logic [WORD_W-1:0] word_q;
            always_ff @(posedge clk) begin
               if (!rst_n)                            word_q <= '0;
               else if (wr_en && (idx == IDX_W'(w)))  word_q <= wdata;
            end
            assign plain_w[w] = word_q;
         end else begin : g_none
            assign plain_w[w] = '0;
         end
      end
   endgenerate

   always_comb begin
      rdata = plain_w[idx];
      case (idx)
         IDX_CTRL: rdata = ctrl_q | (WORD_W'(busy) << CTRL_FLUSH_BIT);
         IDX_STAT: rdata = stat_word(flags_q, code_q, level_q);
         IDX_FALO: rdata = fa_q[WORD_W-1:0];
         IDX_FAHI: rdata = {{(WORD_W-FAHI_W){1'b0}}, fa_q[FADDR_W-1:WORD_W]};
         default:  ;
      endcase
   end

   assign pend = (flags_q != 4'd0);
   assign irq  = ctrl_q[CTRL_IEN_BIT] && pend;

endmodule

// File: rtl/iomcx_regbank.sv
module iomcx_regbank
   import iomcx_pkg::*;
#(
   parameter int unsigned NUM_CTX   = 8,
   parameter int unsigned FLUSH_LAT = 16,
   parameter int unsigned ADDR_W    = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              flt_valid,
   input  logic [2:0]        flt_ctx,
   input  logic [3:0]        flt_flags,
   input  logic [2:0]        flt_code,
   input  logic [1:0]        flt_level,
   input  logic [39:0]       flt_addr,
   output logic              irq
);
   generate
      if (NUM_CTX < 1 || NUM_CTX > CTX_MAX) begin : g_bad_ctx
         $error("iomcx_regbank: NUM_CTX out of range");
      end
      if (ADDR_W < 12) begin : g_bad_addr
         $error("iomcx_regbank: ADDR_W must cover the alias bit");
      end
   endgenerate

   logic [CTX_W-1:0] dec_ctx;
   logic [IDX_W-1:0] dec_idx;
   logic             dec_hit;

   logic [CTX_MAX-1:0]             ctx_irq;
   logic [CTX_MAX-1:0]             ctx_busy;
   logic [CTX_MAX-1:0]             ctx_pend;
   logic [CTX_MAX-1:0][WORD_W-1:0] ctx_rdata;

   fault_t flt;
   assign flt = '{level: flt_level, code: flt_code, flags: flt_flags, addr: flt_addr};

   iomcx_addr_dec #(.ADDR_W(ADDR_W), .NUM_CTX(NUM_CTX)) u_dec (
      .addr (bus_addr),
      .ctx  (dec_ctx),
      .idx  (dec_idx),
      .hit  (dec_hit)
   );

   generate
      for (genvar c = 0; c < CTX_MAX; c++) begin : g_ctx
         if (c < NUM_CTX) begin : g_live
            iomcx_ctx #(.FLUSH_LAT(FLUSH_LAT)) u_ctx (
               .clk    (clk),
               .rst_n  (rst_n),
               .wr_en  (bus_wr && dec_hit && (dec_ctx == CTX_W'(c))),
               .idx    (dec_idx),
               .wdata  (bus_wdata),
               .rdata  (ctx_rdata[c]),
               .flt_en (flt_valid && (flt_ctx == CTX_W'(c))),
               .flt    (flt),
               .irq    (ctx_irq[c]),
               .busy   (ctx_busy[c]),
               .pend   (ctx_pend[c])
            );
         end else begin : g_absent
            assign ctx_rdata[c] = '0;
            assign ctx_irq[c]   = 1'b0;
            assign ctx_busy[c]  = 1'b0;
            assign ctx_pend[c]  = 1'b0;
         end
      end
   endgenerate

   assign bus_rdata = dec_hit ? ctx_rdata[dec_ctx] : '0;
   assign irq       = |ctx_irq;

endmodule

// File: rtl/iomcx_regbank_chk.sv
module iomcx_regbank_chk #(
   parameter int unsigned NUM_CTX = 8,
   parameter int unsigned ADDR_W  = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic              irq,
   input logic [7:0]        ctx_busy,
   input logic [7:0]        ctx_pend
);
   logic unused_chk;
   assign unused_chk = ^{bus_addr[11], bus_addr[1:0]};

   // R10
   reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rst_n) |-> (!irq && ctx_busy == 8'd0 && ctx_pend == 8'd0));

   // R9
   irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ctx_pend != 8'd0));

   generate
      for (genvar c = 0; c < NUM_CTX; c++) begin : g_c
         logic wr_here;
         assign wr_here = bus_wr && (bus_addr[10:9] == 2'b00) && (bus_addr[8:6] == 3'(c));

         // R4
         flush_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_here && bus_addr[5:2] == 4'h0 && bus_wdata[1]) |=> ctx_busy[c]);

         // R7
         pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ctx_pend[c] && !(wr_here && bus_addr[5:2] == 4'h8 && bus_wdata == 32'd0))
            |=> ctx_pend[c]);
      end
   endgenerate

endmodule

bind iomcx_regbank iomcx_regbank_chk #(.NUM_CTX(NUM_CTX), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .irq       (irq),
   .ctx_busy  (ctx_busy),
   .ctx_pend  (ctx_pend)
);

// File: tb/iomcx_regbank_tb_top.sv
module iomcx_regbank_tb_top;
   localparam int NCTX = 6;
   localparam int LAT  = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        flt_valid = 1'b0;
   logic [2:0]  flt_ctx = '0;
   logic [3:0]  flt_flags = '0;
   logic [2:0]  flt_code = '0;
   logic [1:0]  flt_level = '0;
   logic [39:0] flt_addr = '0;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;

   // reference state
   logic [31:0] m_ctrl  [8];
   logic [31:0] m_plain [8][16];
   logic [3:0]  m_flags [8];
   logic [2:0]  m_code  [8];
   logic [1:0]  m_lvl   [8];
   logic [39:0] m_fa    [8];
   int          m_cnt   [8];

   always #10 clk = ~clk;

   iomcx_regbank #(.NUM_CTX(NCTX), .FLUSH_LAT(LAT), .ADDR_W(12)) dut_i (
      .clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
      .flt_valid, .flt_ctx, .flt_flags, .flt_code, .flt_level, .flt_addr, .irq
   );

   function automatic logic [11:0] ra(int c, int i);
      return 12'(c * 64 + i * 4);
   endfunction

   function automatic bit is_plain(int i);
      return (i >= 1 && i <= 7) || i == 10 || i == 11;
   endfunction

   function automatic logic [31:0] exp_rd(logic [11:0] a);
      int c = int'(a[8:6]);
      int i = int'(a[5:2]);
      if (a[10:9] != 2'b00 || c >= NCTX) return 32'd0;
      if (is_plain(i)) return m_plain[c][i];
      case (i)
         0:  return m_ctrl[c] | ((m_cnt[c] > 0) ? 32'd2 : 32'd0);
         8:  return {18'd0, m_lvl[c], 1'b0, m_code[c], 3'd0, m_flags[c][3], 1'b0, m_flags[c][2:0]};
         12: return m_fa[c][31:0];
         13: return {24'd0, m_fa[c][39:32]};
         default: return 32'd0;
      endcase
   endfunction

   function automatic logic exp_irq();
      for (int k = 0; k < NCTX; k++)
         if (m_ctrl[k][2] && m_flags[k] != 4'd0) return 1'b1;
      return 1'b0;
   endfunction

   function automatic void model_reset();
      for (int k = 0; k < 8; k++) begin
         m_ctrl[k] = '0; m_flags[k] = '0; m_code[k] = '0; m_lvl[k] = '0;
         m_fa[k] = '0; m_cnt[k] = 0;
         for (int w = 0; w < 16; w++) m_plain[k][w] = '0;
      end
   endfunction

   function automatic void model_edge(bit wr, logic [11:0] a, logic [31:0] d);
      int c = int'(a[8:6]);
      int i = int'(a[5:2]);
      bit ok = (a[10:9] == 2'b00) && (c < NCTX);
      int fc = int'(flt_ctx);
      for (int k = 0; k < NCTX; k++) begin
         if (wr && ok && c == k && i == 0 && d[1]) m_cnt[k] = LAT;
         else if (m_cnt[k] > 0) m_cnt[k] = m_cnt[k] - 1;
      end
      if (wr && ok) begin
         if (i == 0) m_ctrl[c] = d & 32'h0003_003D;
         else if (is_plain(i)) m_plain[c][i] = d;
         else if (i == 8 && d == 32'd0) begin
            m_flags[c] = '0; m_code[c] = '0; m_lvl[c] = '0;
         end
      end
      if (flt_valid && fc < NCTX && flt_flags != 4'd0 && m_flags[fc] == 4'd0) begin
         m_flags[fc] = flt_flags; m_code[fc] = flt_code;
         m_lvl[fc] = flt_level; m_fa[fc] = flt_addr;
      end
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h (addr %h)", tag, act, exp, bus_addr);
      end
   endtask

   // one clock: drive, compare combinational outputs, advance model at the edge
   task automatic step(string tag, bit wr, logic [11:0] a, logic [31:0] d);
      bus_wr = wr; bus_addr = a; bus_wdata = d;
      #2;
      chk(tag, bus_rdata, exp_rd(a));
      chk({tag, " irq"}, {31'd0, irq}, {31'd0, exp_irq()});
      @(posedge clk);
      model_edge(wr, a, d);
      @(negedge clk);
      bus_wr = 1'b0;
      flt_valid = 1'b0;
   endtask

   task automatic set_flt(int c, logic [3:0] f, logic [2:0] code, logic [1:0] lvl, logic [39:0] ad);
      flt_valid = 1'b1; flt_ctx = 3'(c); flt_flags = f;
      flt_code = code; flt_level = lvl; flt_addr = ad;
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin : main
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10 reset state
      step("R10", 0, ra(0, 0), 0);
      step("R10", 0, ra(3, 8), 0);
      step("R10", 0, ra(5, 13), 0);
      step("R10", 0, ra(2, 4), 0);

      // R5 plain words, distinct per context and word
      for (int c = 0; c < NCTX; c++)
         for (int i = 1; i < 12; i++)
            if (is_plain(i)) step("R5", 1, ra(c, i), 32'hA5C3_0000 ^ (c * 32'h0101_1111) ^ (i << 8));
      for (int c = 0; c < NCTX; c++)
         for (int i = 1; i < 16; i++) step("R5", 0, ra(c, i), 0);

      // R3 control fields
      step("R3", 1, ra(2, 0), 32'hFFFF_FFFD);
      step("R3", 0, ra(2, 0), 0);
      step("R3", 1, ra(2, 0), 32'h0002_0014);
      step("R3", 0, ra(2, 0), 0);
      step("R3", 1, ra(2, 0), 32'h0);

      // R4 flush busy length, restart, no cancel
      step("R4", 1, ra(1, 0), 32'h2);
      for (int n = 0; n < LAT + 2; n++) step("R4", 0, ra(1, 0), 0);
      step("R4", 1, ra(1, 0), 32'h3);
      step("R4", 0, ra(1, 0), 0);
      step("R4", 1, ra(1, 0), 32'h2);
      step("R4", 1, ra(1, 0), 32'h0);
      for (int n = 0; n < LAT + 2; n++) step("R4", 0, ra(1, 0), 0);

      // R1 out-of-range contexts and undecoded bits 10:9
      step("R1", 1, ra(6, 1), 32'hDEAD_BEEF);
      step("R1", 0, ra(6, 1), 0);
      step("R1", 1, ra(7, 2), 32'h1234_5678);
      step("R1", 0, ra(7, 2), 0);
      step("R1", 1, 12'h204, 32'hFEED_FACE);
      step("R1", 0, 12'h204, 0);
      step("R1", 0, ra(0, 1), 0);
      step("R1", 1, 12'h404, 32'hCAFE_0001);
      step("R1", 0, ra(0, 1), 0);
      set_flt(7, 4'b0001, 3'd1, 2'd1, 40'h12_3456_789A);
      step("R1", 0, ra(0, 8), 0);

      // R2 alias window
      step("R2", 1, 12'h800 | ra(3, 1), 32'h0BAD_F00D);
      step("R2", 0, ra(3, 1), 0);
      step("R2", 1, ra(3, 2), 32'h7777_1111);
      step("R2", 0, 12'h800 | ra(3, 2), 0);
      step("R2", 0, 12'h800 | ra(7, 2), 0);

      // R6 first fault captured
      step("R6", 1, ra(4, 0), 32'h4);
      set_flt(4, 4'b0010, 3'd4, 2'd2, 40'hAB_1234_5678);
      step("R6", 0, ra(4, 8), 0);
      step("R6", 0, ra(4, 8), 0);
      step("R6", 0, ra(4, 12), 0);
      step("R6", 0, ra(4, 13), 0);

      // R7 later fault dropped, zero-flag pulse ignored
      set_flt(4, 4'b1001, 3'd5, 2'd3, 40'h01_0000_0002);
      step("R7", 0, ra(4, 8), 0);
      step("R7", 0, ra(4, 8), 0);
      step("R7", 0, ra(4, 12), 0);
      set_flt(5, 4'b0000, 3'd1, 2'd1, 40'h55_5555_5555);
      step("R7", 0, ra(5, 8), 0);
      step("R7", 0, ra(5, 8), 0);
      step("R7", 0, ra(5, 12), 0);

      // R8 nonzero write, read-only address, clear, clear+capture
      step("R8", 1, ra(4, 8), 32'h0000_0017);
      step("R8", 0, ra(4, 8), 0);
      step("R8", 1, ra(4, 12), 32'hFFFF_FFFF);
      step("R8", 1, ra(4, 13), 32'hFFFF_FFFF);
      step("R8", 0, ra(4, 12), 0);
      step("R8", 1, ra(4, 8), 32'h0);
      step("R8", 0, ra(4, 8), 0);
      step("R8", 0, ra(4, 13), 0);
      set_flt(4, 4'b0100, 3'd1, 2'd0, 40'hC0_FFEE_DDCC);
      step("R8", 0, ra(4, 8), 0);
      set_flt(4, 4'b1000, 3'd5, 2'd1, 40'h11_0000_0001);
      step("R8", 1, ra(4, 8), 32'h0);
      step("R8", 0, ra(4, 8), 0);
      step("R8", 0, ra(4, 12), 0);

      // R9 interrupt qualification and OR over contexts
      step("R9", 1, ra(4, 0), 32'h0);
      set_flt(0, 4'b0001, 3'd1, 2'd1, 40'h00_0000_1000);
      step("R9", 0, ra(0, 8), 0);
      step("R9", 0, ra(0, 8), 0);
      step("R9", 1, ra(0, 0), 32'h4);
      step("R9", 0, ra(0, 0), 0);
      step("R9", 1, ra(4, 0), 32'h5);
      step("R9", 1, ra(0, 8), 32'h0);
      step("R9", 0, ra(0, 8), 0);
      step("R9", 1, ra(4, 8), 32'h0);
      step("R9", 0, ra(4, 8), 0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule